// File: doc/BRIEF.md
# Secure Exception Link Value Generator

This unit produces the link value a processor core writes when it enters an exception handler. It also issues the side requests that go with that entry. The link value records:
- the security state of the interrupted code;
- the security state of the handler being entered;
- which stack pointer was selected;
- whether the interrupted code ran in thread mode;
- whether the callee-saved registers have already been put on the stack.

The unit covers fresh entries and tail-chained entries. On a tail-chained entry an incoming link value is updated rather than built from scratch.

Alongside the link value, the unit asks the stacking logic to push the callee-saved registers when secure background code is about to be handed to a non-secure handler. It also raises clear strobes so that the non-secure handler cannot observe secure register contents or flags. Memory stacking, vector fetch and prioritisation belong to neighbouring blocks. A caller presents one request with `start`. The result appears on the registered outputs one cycle later, together with a one-cycle `out_valid` pulse.

Link value fields used below:
- bit 0: target-state
- bit 2: stack-select
- bit 3: thread-mode
- bit 4: frame-type
- bit 5: callee-default
- bit 6: return-state
- bits 31:24: all ones on a fresh entry

Top module: `exc_link_gen`

## Requirements
- R1: While reset is high and after it, until the first request, `out_valid`, `push_callee`, all clear strobes and `link_out` are zero.
- R2: A fresh entry (`tail_chain`=0) with `sec_ext_en`=1 starts from a value with bits 31:24 set, frame-type (bit 4) and callee-default (bit 5) set, return-state (bit 6) equal to `cur_secure`, and bits 23:7 and 1 zero.
- R3: A fresh entry with `sec_ext_en`=0 also sets return-state (bit 6) and target-state (bit 0), and takes stack-select (bit 2) from `stksel_ns`. In this mode `cur_secure` and `tgt_secure` have no effect, and no push or clear is requested.
- R4: On a fresh entry the thread-mode bit (bit 3) is set exactly when `handler_mode`=0. On a tail-chained entry, bit 3 and all other bits not named in R5–R8 pass through unchanged from `link_in`.
- R5: With `sec_ext_en`=1, target-state (bit 0) of the result equals `tgt_secure`.
- R6: Stack-select (bit 2) of the result is `stksel_s` when the effective target is secure, and `stksel_ns` otherwise.
- R7: With `sec_ext_en`=1, return-state=1 and `tgt_secure`=1, a tail-chained entry whose incoming target-state bit is 0 clears callee-default (bit 5). In every other secure-target case, bit 5 is kept.
- R8: With `sec_ext_en`=1, return-state=1 and `tgt_secure`=0, `push_callee` is raised when callee-default is 1, unless the entry is tail-chained with incoming target-state 1. Callee-default is 1 in the result.
- R9: With `sec_ext_en`=1 and `tgt_secure`=0, `clr_caller` and `clr_flags` are raised. `clr_callee` is raised only when the result's return-state bit is 1.
- R10: Outputs update on the clock edge that samples `start`=1. `out_valid` is high for exactly one cycle per request, and `link_out` holds its value between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe; inputs are sampled with it |
| cur_secure | input | 1 | Interrupted code is secure |
| handler_mode | input | 1 | Interrupted code was in handler mode |
| stksel_ns | input | 1 | Stack-select control bit of the non-secure state |
| stksel_s | input | 1 | Stack-select control bit of the secure state |
| tgt_secure | input | 1 | Exception being entered targets the secure state |
| tail_chain | input | 1 | Entry is tail-chained onto an existing frame |
| link_in | input | 32 | Incoming link value for tail-chained entries |
| sec_ext_en | input | 1 | Security extension present |
| link_out | output | 32 | Computed link value |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| push_callee | output | 1 | Request to push the callee-saved registers |
| clr_caller | output | 1 | Clear general registers 0–3 and 12 |
| clr_callee | output | 1 | Clear general registers 4–11 |
| clr_flags | output | 1 | Clear condition, saturation, greater-or-equal and if-then flags |

## Verification
The assertions assume that `start` is held low while reset is high, and that every input is stable around the sampling edge. The bench changes inputs only on falling edges and keeps `start` low during reset. The strobe properties also assume that a tail-chained `link_in` is a value this unit could have produced. The bench therefore feeds only link values whose return-state and callee-default bits form a combination that can occur, plus one pass-through pattern whose return-state bit is 0.

// File: rtl/exc_link_pkg.sv
package exc_link_pkg;

    localparam int LINK_W      = 32;
    localparam int TOP_ONES_W  = 8;
    localparam int BIT_ES      = 0;
    localparam int BIT_SPSEL   = 2;
    localparam int BIT_MODE    = 3;
    localparam int BIT_FTYPE   = 4;
    localparam int BIT_DCRS    = 5;
    localparam int BIT_RET_S   = 6;

    localparam logic [LINK_W-1:0] TOP_ONES =
        {{TOP_ONES_W{1'b1}}, {(LINK_W-TOP_ONES_W){1'b0}}};

    typedef struct packed {
        logic [LINK_W-1:0] link;
        logic              push_callee;
        logic              clr_caller;
        logic              clr_callee;
        logic              clr_flags;
    } link_result_t;

    function automatic logic [LINK_W-1:0] put_bit(
        input logic [LINK_W-1:0] v, input int pos, input logic b);
        logic [LINK_W-1:0] r;
        r      = v;
        r[pos] = b;
        return r;
    endfunction

endpackage

// File: rtl/exc_link_seed.sv
module exc_link_seed
    import exc_link_pkg::*;
(
    input  logic              cur_secure,
    input  logic              handler_mode,
    input  logic              stksel_ns,
    input  logic              sec_ext_en,
    input  logic              tail_chain,
    input  logic [LINK_W-1:0] link_in,
    output logic [LINK_W-1:0] seed
);
    logic [LINK_W-1:0] fresh;

    always_comb begin
        fresh = TOP_ONES;
        fresh = put_bit(fresh, BIT_FTYPE, 1'b1);
        fresh = put_bit(fresh, BIT_DCRS, 1'b1);
        if (sec_ext_en) begin
            fresh = put_bit(fresh, BIT_RET_S, cur_secure);
        end else begin
            fresh = put_bit(fresh, BIT_RET_S, 1'b1);
            fresh = put_bit(fresh, BIT_ES, 1'b1);
            fresh = put_bit(fresh, BIT_SPSEL, stksel_ns);
        end
        fresh = put_bit(fresh, BIT_MODE, ~handler_mode);
        seed  = tail_chain ? link_in : fresh;
    end
endmodule

// File: rtl/exc_link_policy.sv
module exc_link_policy
    import exc_link_pkg::*;
(
    input  logic              sec_ext_en,
    input  logic              tgt_secure,
    input  logic              tail_chain,
    input  logic [LINK_W-1:0] seed,
    output logic [LINK_W-1:0] staged,
    output logic              push_req
);
    logic bg_secure;
    logic old_es;
    logic old_dcrs;

    assign bg_secure = sec_ext_en & seed[BIT_RET_S];
    assign old_es    = seed[BIT_ES];
    assign old_dcrs  = seed[BIT_DCRS];

    always_comb begin
        staged   = seed;
        push_req = 1'b0;
        if (bg_secure) begin
            if (tgt_secure) begin
                if (tail_chain && !old_es)
                    staged = put_bit(staged, BIT_DCRS, 1'b0);
            end else begin
                push_req = old_dcrs & ~(tail_chain & old_es);
                staged   = put_bit(staged, BIT_DCRS, 1'b1);
            end
        end
    end
endmodule

// File: rtl/exc_link_finish.sv
module exc_link_finish
    import exc_link_pkg::*;
(
    input  logic              sec_ext_en,
    input  logic              tgt_secure,
    input  logic              stksel_ns,
    input  logic              stksel_s,
    input  logic [LINK_W-1:0] staged,
    input  logic              push_req,
    output link_result_t      res
);
    logic eff_secure;
    logic to_nonsecure;

    assign eff_secure   = sec_ext_en & tgt_secure;
    assign to_nonsecure = sec_ext_en & ~tgt_secure;

    always_comb begin
        res.link        = staged;
        res.link        = put_bit(res.link, BIT_ES, eff_secure | ~sec_ext_en);
        res.link        = put_bit(res.link, BIT_SPSEL,
                                  eff_secure ? stksel_s : stksel_ns);
        res.push_callee = push_req;
        res.clr_caller  = to_nonsecure;
        res.clr_flags   = to_nonsecure;
        res.clr_callee  = to_nonsecure & staged[BIT_RET_S];
    end
endmodule

// File: rtl/exc_link_gen.sv
module exc_link_gen
    import exc_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cur_secure,
    input  logic              handler_mode,
    input  logic              stksel_ns,
    input  logic              stksel_s,
    input  logic              tgt_secure,
    input  logic              tail_chain,
    input  logic [LINK_W-1:0] link_in,
    input  logic              sec_ext_en,
    output logic [LINK_W-1:0] link_out,
    output logic              out_valid,
    output logic              push_callee,
    output logic              clr_caller,
    output logic              clr_callee,
    output logic              clr_flags
);
    logic [LINK_W-1:0] seed;
    logic [LINK_W-1:0] staged;
    logic              push_req;
    link_result_t      res;

    exc_link_seed u_seed (
        .cur_secure   (cur_secure),
        .handler_mode (handler_mode),
        .stksel_ns    (stksel_ns),
        .sec_ext_en   (sec_ext_en),
        .tail_chain   (tail_chain),
        .link_in      (link_in),
        .seed         (seed)
    );

    exc_link_policy u_policy (
        .sec_ext_en (sec_ext_en),
        .tgt_secure (tgt_secure),
        .tail_chain (tail_chain),
        .seed       (seed),
        .staged     (staged),
        .push_req   (push_req)
    );

    exc_link_finish u_finish (
        .sec_ext_en (sec_ext_en),
        .tgt_secure (tgt_secure),
        .stksel_ns  (stksel_ns),
        .stksel_s   (stksel_s),
        .staged     (staged),
        .push_req   (push_req),
        .res        (res)
    );

    // Result register; strobes exist only in the valid cycle (R1, R10)
    always_ff @(posedge clk) begin
        if (rst) begin
            link_out    <= '0;
            out_valid   <= 1'b0;
            push_callee <= 1'b0;
            clr_caller  <= 1'b0;
            clr_callee  <= 1'b0;
            clr_flags   <= 1'b0;
        end else begin
            out_valid   <= start;
            push_callee <= start & res.push_callee;
            clr_caller  <= start & res.clr_caller;
            clr_callee  <= start & res.clr_callee;
            clr_flags   <= start & res.clr_flags;
            if (start)
                link_out <= res.link;
        end
    end

    assert_valid_follows_start_R10: assert property (@(posedge clk) disable iff (rst)
        start |=> out_valid);
    assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
        !start |=> !out_valid);
    assert_link_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(link_out));
    assert_strobes_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(push_callee | clr_caller | clr_callee | clr_flags));
    assert_callee_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr_callee |-> (clr_caller && clr_flags && link_out[BIT_RET_S]));
    assert_clear_nonsecure_R5: assert property (@(posedge clk) disable iff (rst)
        clr_caller |-> !link_out[BIT_ES]);
    assert_push_shape_R8: assert property (@(posedge clk) disable iff (rst)
        push_callee |-> (link_out[BIT_DCRS] && link_out[BIT_RET_S] && !link_out[BIT_ES]));
endmodule

// File: tb/exc_link_gen_tb.sv
module exc_link_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cur_secure = 1'b0, handler_mode = 1'b0;
    logic        stksel_ns = 1'b0, stksel_s = 1'b0;
    logic        tgt_secure = 1'b0, tail_chain = 1'b0, sec_ext_en = 1'b0;
    logic [31:0] link_in = '0;
    logic [31:0] link_out;
    logic        out_valid, push_callee, clr_caller, clr_callee, clr_flags;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_link_gen dut_i (
        .clk(clk), .rst(rst), .start(start), .cur_secure(cur_secure),
        .handler_mode(handler_mode), .stksel_ns(stksel_ns), .stksel_s(stksel_s),
        .tgt_secure(tgt_secure), .tail_chain(tail_chain), .link_in(link_in),
        .sec_ext_en(sec_ext_en), .link_out(link_out), .out_valid(out_valid),
        .push_callee(push_callee), .clr_caller(clr_caller),
        .clr_callee(clr_callee), .clr_flags(clr_flags)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // Drive one request at a falling edge, sample on the next falling edge
    task automatic request(input logic cs, input logic hm, input logic sn,
                           input logic ss, input logic ts, input logic tc,
                           input logic [31:0] li, input logic ext);
        @(negedge clk);
        cur_secure = cs; handler_mode = hm; stksel_ns = sn; stksel_s = ss;
        tgt_secure = ts; tail_chain = tc; link_in = li; sec_ext_en = ext;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [31:0] lk,
                              input logic p, input logic cc,
                              input logic ce, input logic cf);
        check(req, "valid", {31'd0, out_valid}, 32'd1);
        check(req, "link", link_out, lk);
        check(req, "strobes", {28'd0, push_callee, clr_caller, clr_callee, clr_flags},
              {28'd0, p, cc, ce, cf});
    endtask

    task automatic t_reset();
        check("R1", "reset valid", {31'd0, out_valid}, 32'd0);
        check("R1", "reset link", link_out, 32'd0);
        check("R1", "reset strobes",
              {28'd0, push_callee, clr_caller, clr_callee, clr_flags}, 32'd0);
    endtask

    task automatic t_fresh_secure_to_secure();   // R2 R4 R5 R6
        request(1, 0, 0, 1, 1, 0, 32'h0, 1);
        expect_out("R2", 32'hFF00007D, 0, 0, 0, 0);
    endtask

    task automatic t_fresh_ns_to_ns();           // R2 R4 R6 R9
        request(0, 1, 1, 0, 0, 0, 32'h0, 1);
        expect_out("R9", 32'hFF000034, 0, 1, 0, 1);
    endtask

    task automatic t_fresh_secure_to_ns();       // R8 R9
        request(1, 1, 0, 1, 0, 0, 32'h0, 1);
        expect_out("R8", 32'hFF000070, 1, 1, 1, 1);
    endtask

    task automatic t_no_extension();             // R3
        request(1, 0, 1, 0, 1, 0, 32'h0, 0);
        expect_out("R3", 32'hFF00007D, 0, 0, 0, 0);
        request(0, 0, 0, 1, 0, 0, 32'h0, 0);
        expect_out("R3", 32'hFF000079, 0, 0, 0, 0);
    endtask

    task automatic t_tail_secure_target();       // R7
        request(0, 0, 0, 0, 1, 1, 32'hFF000068, 1);
        expect_out("R7", 32'hFF000049, 0, 0, 0, 0);
        request(0, 0, 0, 1, 1, 1, 32'hFF000069, 1);
        expect_out("R7", 32'hFF00006D, 0, 0, 0, 0);
    endtask

    task automatic t_tail_ns_target();           // R8 R9
        request(0, 0, 0, 0, 0, 1, 32'hFF000061, 1);
        expect_out("R8", 32'hFF000060, 0, 1, 1, 1);
        request(0, 0, 0, 0, 0, 1, 32'hFF000041, 1);
        expect_out("R8", 32'hFF000060, 0, 1, 1, 1);
        request(0, 0, 0, 0, 0, 1, 32'hFF000060, 1);
        expect_out("R8", 32'hFF000060, 1, 1, 1, 1);
    endtask

    task automatic t_tail_passthrough();         // R4 R6
        request(0, 0, 1, 0, 0, 1, 32'hA5A5A582, 1);
        expect_out("R4", 32'hA5A5A586, 0, 1, 0, 1);
    endtask

    task automatic t_timing();                   // R10
        request(1, 0, 0, 1, 1, 0, 32'h0, 1);
        expect_out("R10", 32'hFF00007D, 0, 0, 0, 0);
        cur_secure = 0; tgt_secure = 0;
        @(negedge clk);
        check("R10", "valid drops", {31'd0, out_valid}, 32'd0);
        check("R10", "link holds", link_out, 32'hFF00007D);
        @(negedge clk);
        cur_secure = 0; handler_mode = 1; stksel_ns = 1; tgt_secure = 0;
        tail_chain = 0; sec_ext_en = 1; start = 1;
        @(negedge clk);
        check("R10", "b2b first valid", {31'd0, out_valid}, 32'd1);
        check("R10", "b2b first link", link_out, 32'hFF000034);
        cur_secure = 1; handler_mode = 0; stksel_s = 1; tgt_secure = 1;
        @(negedge clk);
        start = 0;
        check("R10", "b2b second valid", {31'd0, out_valid}, 32'd1);
        check("R10", "b2b second link", link_out, 32'hFF00007D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fresh_secure_to_secure();
        t_fresh_ns_to_ns();
        t_fresh_secure_to_ns();
        t_no_extension();
        t_tail_secure_target();
        t_tail_ns_target();
        t_tail_passthrough();
        t_timing();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule